// File: doc/BRIEF.md
# DRAM Refresh Timer

This block paces dynamic memory refresh. A down-counter, reloaded from a programmable period register, runs while the unit is enabled. Each time it expires, the block raises a refresh request. The request stays up until the memory sequencer acknowledges it. Each acknowledged refresh advances a row address that the sequencer uses for the refresh cycle. When the block is enabled, it also tells the pad logic to turn a shared chip-select pin into the refresh strobe.

Software sees two 16-bit registers through a simple write port and a combinational read port:

- The control/status register holds the enable bit in bit 15. Its bits [8:0] show the live counter.
- The period register sets the reload value.

Disabling the block empties the counter and withdraws any pending request. The row address is kept, so refresh resumes at the next row when the block is enabled again.

Top module: `dram_refresh_ctl`

## Requirements
- R1: After reset, the control register reads 0000h, `rfsh_req` is 0, `strobe_sel` is 0 and `rfsh_addr` is 0.
- R2: A write with `wr_sel`=0 loads bit 15 of `wr_data` into the enable flag. `strobe_sel` equals the enable flag.
- R3: A control write with bit 15 = 0 clears the counter to 0 and drops any pending request. While disabled, the counter stays 0 and no request is raised.
- R4: `rfsh_addr` keeps its value across a disable and a later re-enable.
- R5: On a read with `rd_sel`=0, bit 15 is the enable flag, bits [14:9] are 0 and bits [8:0] are the live counter. The value written into bits [8:0] has no effect on the counter.
- R6: A write with `wr_sel`=1 stores `wr_data[8:0]` as the period P. A read with `rd_sel`=1 returns P in bits [8:0], with bits [15:9] zero. The period register has no reset value.
- R7: Counter timing:
  - The clock edge that enables the block is edge 0.
  - Edge 1 loads P into the counter.
  - The counter then decrements by one per clock.
  - The edge at which the counter equals 1 reloads P and raises the request, so the first request appears after edge P+1 and later expiries follow every P clocks.
  - With P = 0, no request is ever raised.
- R8: A request stays high until a clock edge where `rfsh_ack`=1. That edge clears it, unless an expiry occurs at the same edge, and increments `rfsh_addr` by one modulo 2^ADDR_W. `rfsh_ack` without a request has no effect.
- R9: An expiry while a request is pending is merged into that request. One acknowledge then advances the address by exactly one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 period |
| wr_data | input | 16 | Write data |
| rd_sel | input | 1 | Read source: 0 control/status, 1 period |
| rd_data | output | 16 | Read data (combinational) |
| rfsh_req | output | 1 | Refresh request, held until acknowledged |
| rfsh_ack | input | 1 | Refresh acknowledge from the sequencer |
| rfsh_addr | output | ADDR_W | Refresh row address |
| strobe_sel | output | 1 | Switches the shared chip-select pin to refresh strobe |

## Verification
On every cycle, the assertions check the following:
- the counter steps down by one while enabled;
- a disabled unit holds an empty counter and no request;
- an unacknowledged request persists;
- the address moves only on an acknowledged request;
- the reserved read bits stay zero.

Only the bench scenarios can show the absolute spacing of requests for each period value, the first-request latency after enabling, address retention across disable, merging of overlapping expiries and address wrap-around. The bench checks these by counting clocks against values it computes from the period.

// File: rtl/dram_refresh_ctl.sv
module dram_refresh_ctl #(
  parameter int REG_W  = 16,
  parameter int CNT_W  = 9,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              rd_sel,
  output logic [REG_W-1:0]  rd_data,
  output logic              rfsh_req,
  input  logic              rfsh_ack,
  output logic [ADDR_W-1:0] rfsh_addr,
  output logic              strobe_sel
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam int RSV_W = REG_W - 1 - CNT_W;

  logic              en;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  period;
  logic              req;
  logic [ADDR_W-1:0] addr;

  wire ctl_wr    = wr_en && !wr_sel;
  wire per_wr    = wr_en && wr_sel;
  wire going_off = ctl_wr && !wr_data[REG_W-1];
  wire expire    = en && (cnt == ONE);
  wire take      = req && rfsh_ack;

  always_ff @(posedge clk)
    if (!rst_n)      en <= 1'b0;
    else if (ctl_wr) en <= wr_data[REG_W-1];

  always_ff @(posedge clk)
    if (!rst_n)                 cnt <= '0;
    else if (going_off || !en)  cnt <= '0;
    else if (cnt <= ONE)        cnt <= period;
    else                        cnt <= cnt - ONE;

  always_ff @(posedge clk)
    if (per_wr) period <= wr_data[CNT_W-1:0];

  always_ff @(posedge clk)
    if (!rst_n)                 req <= 1'b0;
    else if (going_off || !en)  req <= 1'b0;
    else if (expire)            req <= 1'b1;
    else if (take)              req <= 1'b0;

  always_ff @(posedge clk)
    if (!rst_n)    addr <= '0;
    else if (take) addr <= addr + ADDR_W'(1);

  assign rd_data    = rd_sel ? {{(REG_W-CNT_W){1'b0}}, period}
                             : {en, {RSV_W{1'b0}}, cnt};
  assign rfsh_req   = req;
  assign rfsh_addr  = addr;
  assign strobe_sel = en;

  a_r3_off_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (cnt == '0 && !req));
  a_r5_rsv_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_sel |-> rd_data[REG_W-2:CNT_W] == '0);
  a_r7_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cnt > ONE && !going_off) |=> cnt == $past(cnt) - ONE);
  a_r8_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !rfsh_ack && !going_off) |=> req);
  a_r8_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> addr == $past(addr) + ADDR_W'(1));
  a_r8_addr_still: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(addr));
  a_r9_merge: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && req && !going_off) |=> req);
endmodule

// File: tb/dram_refresh_ctl_test.sv
module dram_refresh_ctl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0, rfsh_ack = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        rfsh_req, strobe_sel;
  logic [7:0]  rfsh_addr;
  int          n_run = 0, n_fail = 0;
  logic        done = 1'b0;

  always #2.5 clk = ~clk;

  dram_refresh_ctl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .rfsh_req(rfsh_req), .rfsh_ack(rfsh_ack),
    .rfsh_addr(rfsh_addr), .strobe_sel(strobe_sel)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [15:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic spacing(input int p);
    int n;
    logic [7:0] a0;
    wr(1'b0, 16'h0000);
    wr(1'b1, 16'(p));
    wr(1'b0, 16'h8000);
    a0 = rfsh_addr;
    n = 0;
    while (!rfsh_req && n < p + 5) begin tick(); n++; end
    chk(n == p + 1, "R7 first request latency", n, p + 1);
    rfsh_ack = 1'b1; tick(); rfsh_ack = 1'b0;
    chk(rfsh_addr == a0 + 8'd1, "R8 ack advances address", rfsh_addr, a0 + 8'd1);
    chk(!rfsh_req, "R8 ack clears request", rfsh_req, 0);
    n = 1;
    while (!rfsh_req && n < p + 5) begin tick(); n++; end
    chk(n == p, "R7 request spacing", n, p);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    rd_sel = 1'b0;
    chk(rd_data == 16'h0000, "R1 control reads zero", rd_data, 0);
    chk(!rfsh_req && !strobe_sel && rfsh_addr == 0, "R1 outputs idle",
        {rfsh_req, strobe_sel, rfsh_addr}, 0);

    rfsh_ack = 1'b1; tick(); rfsh_ack = 1'b0;
    chk(rfsh_addr == 0, "R8 ack without request ignored", rfsh_addr, 0);

    wr(1'b1, 16'hFFFF);
    rd_sel = 1'b1; #1;
    chk(rd_data == 16'h01FF, "R6 period readback", rd_data, 16'h01FF);
    rd_sel = 1'b0;
    wr(1'b0, 16'hFFFF);
    chk(strobe_sel, "R2 enable drives strobe_sel", strobe_sel, 1);
    chk(rd_data[15:9] == 7'h40, "R5 reserved bits zero", rd_data[15:9], 7'h40);
    chk(rd_data[8:0] == 9'h000, "R5 count empty on enable edge", rd_data[8:0], 0);
    tick();
    chk(rd_data[8:0] == 9'h1FF, "R7 load period", rd_data[8:0], 9'h1FF);
    wr(1'b0, 16'h8003);
    chk(rd_data[8:0] == 9'h1FE, "R5 count write ignored", rd_data[8:0], 9'h1FE);

    for (int p = 2; p <= 20; p++) spacing(p);
    spacing(100);
    spacing(511);

    wr(1'b0, 16'h0000);
    wr(1'b1, 16'd0);
    wr(1'b0, 16'h8000);
    begin
      int seen = 0;
      for (int i = 0; i < 40; i++) begin tick(); if (rfsh_req) seen++; end
      chk(seen == 0, "R7 period zero never requests", seen, 0);
    end

    wr(1'b0, 16'h0000);
    wr(1'b1, 16'd17);
    wr(1'b0, 16'h8000);
    tick(); tick(); tick();
    chk(rd_data[8:0] == 9'd15, "R7 live count", rd_data[8:0], 15);

    begin
      logic [7:0] a0;
      wr(1'b0, 16'h0000);
      wr(1'b1, 16'd3);
      wr(1'b0, 16'h8000);
      a0 = rfsh_addr;
      for (int k = 1; k <= 11; k++) tick();
      chk(rfsh_req && rfsh_addr == a0, "R9 merged request pending", rfsh_addr, a0);
      rfsh_ack = 1'b1; tick(); rfsh_ack = 1'b0;
      chk(!rfsh_req && rfsh_addr == a0 + 8'd1, "R9 one ack one step", rfsh_addr, a0 + 8'd1);
      tick();
      chk(rfsh_req, "R9 next expiry after merge", rfsh_req, 1);
      chk(rfsh_addr == a0 + 8'd1, "R8 address held without ack", rfsh_addr, a0 + 8'd1);

      tick();
      wr(1'b0, 16'h01FF);
      chk(rd_data[8:0] == 0 && !rfsh_req, "R3 disable clears count and request",
          rd_data[8:0], 0);
      chk(!strobe_sel, "R2 strobe_sel follows disable", strobe_sel, 0);
      chk(rfsh_addr == a0 + 8'd1, "R4 address kept on disable", rfsh_addr, a0 + 8'd1);
      begin
        int seen = 0;
        for (int i = 0; i < 50; i++) begin
          tick(); if (rfsh_req || rd_data[8:0] != 0) seen++;
        end
        chk(seen == 0, "R3 disabled stays idle", seen, 0);
      end
      wr(1'b0, 16'h8000);
      chk(rfsh_addr == a0 + 8'd1, "R4 address kept on re-enable", rfsh_addr, a0 + 8'd1);
      begin
        int n = 0;
        while (!rfsh_req && n < 10) begin tick(); n++; end
        chk(n == 4, "R7 latency after re-enable", n, 4);
      end
    end

    begin
      logic [7:0] a0;
      int takes = 0;
      wr(1'b0, 16'h0000);
      wr(1'b1, 16'd1);
      a0 = rfsh_addr;
      wr(1'b0, 16'h8000);
      rfsh_ack = 1'b1;
      for (int i = 0; i < 300; i++) begin
        if (rfsh_req) takes++;
        tick();
      end
      rfsh_ack = 1'b0;
      tick();
      chk(takes > 256, "R8 wrap exercised", takes, 257);
      chk(rfsh_addr == 8'(a0 + takes), "R8 address wraps", rfsh_addr, 8'(a0 + takes));
      chk(rfsh_req, "R7 period one keeps request high", rfsh_req, 1);
      wr(1'b0, 16'h0000);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule